// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the internal word address of a pipelined burst static memory. An external address is captured whenever an address strobe starts an access. After that, the two low address bits step through a four-word group, one step on each qualifying advance request. The upper bits stay where they were loaded. A mode input picks the stepping order. With mode high, the low bits follow the interleaved cache-line order, which is the start value XORed with a beat count. With mode low, they follow a linear count that wraps inside the group.

There are two strobes. The processor strobe loads only while the master chip enable is active. The controller strobe loads only while the processor strobe is high, and it ignores the chip enable. Which advance request counts depends on the direction of the access. A read beat advances when write enable is high. A write beat advances when a byte-lane write is asserted. In both cases the advance input must be low and both strobes must be high.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `burst_addr` is all zeros.
- R2: On an edge where `proc_strobe_n` is 0 and `chip_en_n` is 0, the external address is loaded and appears on `burst_addr` after that edge. If `proc_strobe_n` is 0 and `chip_en_n` is 1, nothing is loaded.
- R3: On an edge where `ctrl_strobe_n` is 0 and `proc_strobe_n` is 1, the external address is loaded whatever the value of `chip_en_n`.
- R4: A load takes priority, so `adv_n` has no effect on a loading edge. The output after that edge equals the external address.
- R5: Read advance: the beat count increases by one when `we_n`=1, `adv_n`=0 and both strobes are 1.
- R6: Write advance: the beat count increases by one when `we_n`=0, `byte_wr_n`=0, `adv_n`=0 and both strobes are 1. If `we_n`=0 and `byte_wr_n`=1, the address holds.
- R7: With `mode_intlv`=1, `burst_addr[1:0]` equals the starting low bits XOR the beat count.
- R8: With `mode_intlv`=0, `burst_addr[1:0]` equals the starting low bits plus the beat count, modulo 4.
- R9: `burst_addr[ADDR_W-1:2]` changes only on a load. After four advances the low bits return to their starting value and counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External address to load |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| chip_en_n | input | 1 | Master chip enable, active low; gates the processor strobe only |
| adv_n | input | 1 | Burst advance request, active low |
| we_n | input | 1 | Write enable, active low |
| byte_wr_n | input | 1 | Any byte-lane write asserted, active low |
| mode_intlv | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_addr | output | ADDR_W | Current internal word address |

## Verification
A wrong beat count or a wrong starting value shows on the two low bits of `burst_addr` right after the edge that caused it. The error does not fade away: it persists until the next load. A missed or extra advance moves every later beat of the group by one position. The bench uses the linear and the interleaved orders, which give different sequences for odd start values, to tell the two orders apart. A corrupted upper field would show as a change in `burst_addr[ADDR_W-1:2]` on an edge with no load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LANE_W = 2;
  typedef logic [LANE_W-1:0] lane_t;

  // Low address bits for a given start value, beat number and order.
  function automatic lane_t order_lo(lane_t start, lane_t beat, logic intlv);
    lane_t r;
    if (intlv) r = start ^ beat;
    else       r = start + beat;
    return r;
  endfunction

  function automatic lane_t beat_next(lane_t beat);
    return beat + lane_t'(1);
  endfunction
endpackage

// File: rtl/burst_qualify.sv
module burst_qualify (
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic chip_en_n,
  input  logic adv_n,
  input  logic we_n,
  input  logic byte_wr_n,
  output logic load_proc,
  output logic load_ctrl,
  output logic step_ok
);
  logic strobes_idle;
  logic dir_ok;

  always_comb begin
    load_proc    = !proc_strobe_n && !chip_en_n;
    load_ctrl    = !ctrl_strobe_n && proc_strobe_n;
    strobes_idle = proc_strobe_n && ctrl_strobe_n;
    // read beats need we_n high; write beats need a byte lane asserted
    dir_ok       = we_n || !byte_wr_n;
    step_ok      = strobes_idle && !adv_n && dir_ok;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  output lane_t beat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat_q <= '0;
    else if (clear) beat_q <= '0;
    else if (step)  beat_q <= beat_next(beat_q);
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-LANE_W-1:0] upper_q,
  output lane_t             start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load) begin
      upper_q <= ext_addr[ADDR_W-1:LANE_W];
      start_q <= ext_addr[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              byte_wr_n,
  input  logic              mode_intlv,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int UP_W = ADDR_W - LANE_W;

  logic            load_proc;
  logic            load_ctrl;
  logic            load_any;
  logic            step_ok;
  logic            step_eff;
  lane_t           beat_q;
  lane_t           start_q;
  logic [UP_W-1:0] upper_q;

  burst_qualify u_qual (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_en_n     (chip_en_n),
    .adv_n         (adv_n),
    .we_n          (we_n),
    .byte_wr_n     (byte_wr_n),
    .load_proc     (load_proc),
    .load_ctrl     (load_ctrl),
    .step_ok       (step_ok)
  );

  assign load_any = load_proc || load_ctrl;
  assign step_eff = step_ok && !load_any;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_any),
    .ext_addr (ext_addr),
    .upper_q  (upper_q),
    .start_q  (start_q)
  );

  burst_beat_cnt u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load_any),
    .step   (step_eff),
    .beat_q (beat_q)
  );

  assign burst_addr = {upper_q, order_lo(start_q, beat_q, mode_intlv)};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] burst_addr,
  input logic              load_proc,
  input logic              load_ctrl,
  input logic              step_ok,
  input logic [1:0]        beat_q,
  input logic [1:0]        start_q
);
  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_proc |=> burst_addr == $past(ext_addr)); // R2
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_ctrl |=> burst_addr == $past(ext_addr)); // R3
  AST_LOAD_CLEARS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_proc || load_ctrl) |=> beat_q == 2'b00); // R4
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !load_proc && !load_ctrl) |=> beat_q == 2'($past(beat_q) + 2'd1)); // R5
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_proc || load_ctrl || step_ok) |=> $stable(beat_q) && $stable(start_q)); // R6
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_proc || load_ctrl) |=> $stable(burst_addr[ADDR_W-1:2])); // R9
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_addr   (ext_addr),
  .burst_addr (burst_addr),
  .load_proc  (load_proc),
  .load_ctrl  (load_ctrl),
  .step_ok    (step_ok),
  .beat_q     (beat_q),
  .start_q    (start_q)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          ps_n = 1'b1, cs_n = 1'b1, ce_n = 1'b1;
  logic          adv_n = 1'b1, we_n = 1'b1, bw_n = 1'b1, md = 1'b1;
  logic [AW-1:0] burst_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_beat = '0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .proc_strobe_n(ps_n), .ctrl_strobe_n(cs_n), .chip_en_n(ce_n),
    .adv_n(adv_n), .we_n(we_n), .byte_wr_n(bw_n),
    .mode_intlv(md), .burst_addr(burst_addr)
  );

  // Expected low bits, written as a walk through the beats
  function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] b, logic il);
    logic [1:0] v = s;
    for (int i = 0; i < b; i++) begin
      if (il) v = s ^ 2'(i + 1);
      else    v = v + 2'd1;
    end
    return v;
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (burst_addr !== exp) begin
      fails++;
      $display("FAIL %s: burst_addr=%h expected=%h", tag, burst_addr, exp);
    end
  endtask

  // Called at a falling edge: drive, model the rising edge, check at next fall
  task automatic cyc(input logic [AW-1:0] a, input logic ps, cs, ce, adv, we, bw,
                     input logic mode, input string tag);
    logic lp, lc, st;
    ext_addr = a; ps_n = ps; cs_n = cs; ce_n = ce;
    adv_n = adv; we_n = we; bw_n = bw; md = mode;
    lp = !ps && !ce;
    lc = !cs && ps;
    st = ps && cs && !adv && (we || !bw);
    @(posedge clk);
    if (lp || lc) begin
      m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
    end else if (st) begin
      m_beat = m_beat + 2'd1;
    end
    @(negedge clk);
    check({m_up, exp_lo(m_start, m_beat, mode)}, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    checks++;
    if (burst_addr !== '0) begin
      fails++;
      $display("FAIL R1: burst_addr=%h expected=0", burst_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check('0, "R1");

    // R2: processor strobe blocked by inactive chip enable
    cyc(17'h1ABC5, 0, 1, 1, 1, 1, 1, 1, "R2 blocked");
    // R2 + R4: load with advance low, interleaved start 2
    cyc(17'h0F0F2, 0, 1, 0, 0, 1, 1, 1, "R2 R4");
    // R5 + R7: read beats 3,0,1 then wrap to 2 (R9)
    cyc(17'h00000, 1, 1, 1, 0, 1, 1, 1, "R5 R7");
    cyc(17'h00000, 1, 1, 1, 0, 1, 1, 1, "R7");
    cyc(17'h00000, 1, 1, 1, 0, 1, 1, 1, "R7");
    cyc(17'h00000, 1, 1, 1, 0, 1, 1, 1, "R9 wrap");
    // R3: controller strobe loads with chip enable inactive, linear start 1
    cyc(17'h12341, 1, 0, 1, 1, 1, 1, 0, "R3");
    // R3: controller strobe ignored while processor strobe low, chip enable off
    cyc(17'h00003, 0, 0, 1, 1, 1, 1, 0, "R3 blocked");
    // R6: write without byte lane holds
    cyc(17'h00000, 1, 1, 1, 0, 0, 1, 0, "R6 hold");
    // R6 + R8: write beats in linear order 2,3,0,1
    cyc(17'h00000, 1, 1, 1, 0, 0, 0, 0, "R6 R8");
    cyc(17'h00000, 1, 1, 1, 0, 0, 0, 0, "R8");
    cyc(17'h00000, 1, 1, 1, 0, 0, 0, 0, "R8");
    cyc(17'h00000, 1, 1, 1, 0, 0, 0, 0, "R9 wrap");
    // R5: advance high holds
    cyc(17'h00000, 1, 1, 1, 1, 1, 1, 0, "R5 hold");

    for (int i = 0; i < 4000; i++) begin
      logic ps, cs, ce, adv, we, bw, mo;
      string tag;
      ps  = ($urandom % 5) != 0;
      cs  = ($urandom % 5) != 0;
      ce  = $urandom % 2;
      adv = ($urandom % 4) == 0;
      we  = $urandom % 2;
      bw  = $urandom % 2;
      mo  = (i / 500) % 2;
      if (!ps && !ce)      tag = "R2 rand";
      else if (!cs && ps)  tag = "R3 rand";
      else if (mo)         tag = "R7 rand";
      else                 tag = "R8 rand";
      cyc(AW'($urandom), ps, cs, ce, adv, we, bw, mo, tag);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule